// File: doc/BRIEF.md
# Prescaled PWM Timer with One-Shot

This block generates a pulse-width-modulated waveform from a 16-bit up-counter. An 8-bit prescaler divides the system clock so the counter advances once every (prescale + 1) clocks. The counter climbs from zero to a programmable period value and then restarts from zero, so every waveform period spans (period + 1) counter ticks. The output level comes from comparing the running count with a compare value. A polarity control flips the waveform.

A one-shot mode emits exactly one waveform period and then parks the output low. Two event sources are provided, each with a sticky pending flag, a mask and an interrupt line. A compare match raises one of them and leaves the counter running. Reaching the period value raises the other. Software reaches the block through a single-cycle register write port. New period and compare values are staged and take effect only at the next period boundary.

Top module: `pwm_timer`

## Requirements
- R1: While enabled, the counter advances once every (prescale + 1) clock cycles, with prescale written at address 2 (bits 7:0, range 0 to 255).
- R2: The counter starts at 0 and increments on each tick. On the tick where it equals the period value, it returns to 0, so a period lasts (period + 1) ticks. A compare match does not disturb the count.
- R3: With invert at 0, the output is high while count < compare and low while count >= compare.
- R4: With invert at 1 (control bit 1), the output is the complement of the R3 waveform while running.
- R5: Mode field value 3'b111 (control bits 4:2) selects one-shot. Exactly one period is produced, after which the output stays low whatever invert is set to. Any other mode value runs continuously.
- R6: A match event (tick with count equal to compare) and an overflow event (tick with count equal to period) each set a sticky pending flag, visible from the next cycle. Writing address 4 with bit 0 set clears the match flag, and with bit 1 set clears the overflow flag. A new event in the same cycle wins over a clear.
- R7: irqMatch is high exactly when match is pending and the match mask (control bit 5) is 0. irqOverflow is high exactly when overflow is pending and the overflow mask (control bit 6) is 0.
- R8: Period (address 0) and compare (address 1) writes made while running take effect only from the first tick after the next overflow.
- R9: With enable (control bit 0) at 0, the prescaler and counter are held at 0 and the output is low. Setting enable again starts a fresh period, including a fresh one-shot.
- R10: Register writes occur on a clock edge with wrEn high. Address 3 is the control register (enable, invert, mode, masks). Reset leaves every register at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| pwmOut | output | 1 | PWM waveform |
| irqMatch | output | 1 | Compare-match interrupt |
| irqOverflow | output | 1 | Period-overflow interrupt |

## Verification
The properties assume reset is asserted before the first edge. They also assume that software never changes the live period or compare values directly; only the staged copies are writable. Configuration is therefore written while the timer is disabled. The only exceptions are the deliberate mid-period writes that exercise staging and the write-one-to-clear accesses. Those are timed away from overflow edges, so the expected cycle stays unambiguous. The sweep covers small periods, compare values on both sides of the period, prescale 0 to 2, both polarities and both modes. Every output is predicted from tick arithmetic.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD   = 3'd0,
    REG_COMPARE  = 3'd1,
    REG_PRESCALE = 3'd2,
    REG_CONTROL  = 3'd3,
    REG_PENDCLR  = 3'd4
  } regAddr_e;

  localparam logic [2:0] MODE_ONESHOT = 3'b111;

  // control -> datapath strobes
  typedef struct packed {
    logic run;
    logic tick;
    logic invert;
    logic oneShot;
  } dpStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic match;
    logic overflow;
  } dpEvent_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  input  dpEvent_t            ev,
  output dpStrobe_t           strobe,
  output logic [CNT_W-1:0]    stagedPeriod,
  output logic [CNT_W-1:0]    stagedCompare,
  output logic                irqMatch,
  output logic                irqOverflow
);
  logic [PRE_W-1:0] preVal;
  logic [PRE_W-1:0] presc;
  logic             enable, invert, maskMatch, maskOvf;
  logic [2:0]       mode;
  logic             pendMatch, pendOvf;
  logic             clrMatch, clrOvf;

  // register write decode (R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedPeriod  <= '0;
      stagedCompare <= '0;
      preVal        <= '0;
      enable        <= 1'b0;
      invert        <= 1'b0;
      mode          <= '0;
      maskMatch     <= 1'b0;
      maskOvf       <= 1'b0;
    end else if (wrEn) begin
      case (regAddr_e'(wrAddr))
        REG_PERIOD:   stagedPeriod  <= wrData;
        REG_COMPARE:  stagedCompare <= wrData;
        REG_PRESCALE: preVal        <= wrData[PRE_W-1:0];
        REG_CONTROL: begin
          enable    <= wrData[0];
          invert    <= wrData[1];
          mode      <= wrData[4:2];
          maskMatch <= wrData[5];
          maskOvf   <= wrData[6];
        end
        default: ;
      endcase
    end
  end

  // prescaler (R1); >= keeps a shrunken limit from running the long way round
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 presc <= '0;
    else if (!enable)          presc <= '0;
    else if (presc >= preVal)  presc <= '0;
    else                       presc <= presc + 1'b1;
  end

  always_comb begin
    strobe.run     = enable;
    strobe.tick    = enable && (presc >= preVal);
    strobe.invert  = invert;
    strobe.oneShot = (mode == MODE_ONESHOT);
  end

  // sticky pending flags, event wins over clear (R6)
  assign clrMatch = wrEn && (regAddr_e'(wrAddr) == REG_PENDCLR) && wrData[0];
  assign clrOvf   = wrEn && (regAddr_e'(wrAddr) == REG_PENDCLR) && wrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMatch <= 1'b0;
      pendOvf   <= 1'b0;
    end else begin
      pendMatch <= ev.match    | (pendMatch & ~clrMatch);
      pendOvf   <= ev.overflow | (pendOvf   & ~clrOvf);
    end
  end

  assign irqMatch    = pendMatch & ~maskMatch;
  assign irqOverflow = pendOvf   & ~maskOvf;

  p_presc_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (presc == '0));
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pendMatch && !clrMatch) |=> pendMatch);
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    ev.overflow |=> pendOvf);
endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] stagedPeriod,
  input  logic [CNT_W-1:0] stagedCompare,
  output dpEvent_t         ev,
  output logic             pwmOut
);
  logic [CNT_W-1:0] cnt, actPeriod, actCompare;
  logic             shotDone;
  logic             step, wrap;

  assign wrap = (cnt == actPeriod);
  assign step = strobe.tick && !shotDone;

  // counter with staged reload at period boundary (R2, R8, R5, R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      actPeriod  <= '0;
      actCompare <= '0;
      shotDone   <= 1'b0;
    end else if (!strobe.run) begin
      cnt        <= '0;
      actPeriod  <= stagedPeriod;
      actCompare <= stagedCompare;
      shotDone   <= 1'b0;
    end else if (step) begin
      if (wrap) begin
        cnt        <= '0;
        actPeriod  <= stagedPeriod;
        actCompare <= stagedCompare;
        if (strobe.oneShot) shotDone <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ev.match    = step && (cnt == actCompare);
  assign ev.overflow = step && wrap;

  assign pwmOut = strobe.run && !shotDone && (strobe.invert ^ (cnt < actCompare));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= actPeriod);
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && step && wrap) |=> (cnt == '0));
  p_match_keeps_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && ev.match && !wrap) |=> (cnt == $past(cnt) + 1'b1));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (cnt == '0));
  p_shot_park_r5: assert property (@(posedge clk) disable iff (!rstN)
    shotDone |-> (cnt == '0 && !pwmOut));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pwmOut,
  output logic              irqMatch,
  output logic              irqOverflow
);
  dpStrobe_t        strobe;
  dpEvent_t         ev;
  logic [CNT_W-1:0] stagedPeriod, stagedCompare;

  pwm_timer_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ev(ev), .strobe(strobe), .stagedPeriod(stagedPeriod),
    .stagedCompare(stagedCompare), .irqMatch(irqMatch), .irqOverflow(irqOverflow)
  );

  pwm_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stagedPeriod(stagedPeriod),
    .stagedCompare(stagedCompare), .ev(ev), .pwmOut(pwmOut)
  );
endmodule

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmOut, irqMatch, irqOverflow;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  pwm_timer u_pwm_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .irqMatch(irqMatch), .irqOverflow(irqOverflow)
  );

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int ctrlWord(int en, int inv, int shot, int mM, int mO);
    return en | (inv << 1) | ((shot != 0 ? 7 : 0) << 2) | (mM << 5) | (mO << 6);
  endfunction

  task automatic startCfg(input int n, input int c, input int p, input int cw);
    wr(3, 0); wr(0, n); wr(1, c); wr(2, p); wr(4, 3); wr(3, cw);
  endtask

  task automatic sweepOne(input int n, input int c, input int p, input int inv, input int shot);
    int mM = p & 1;
    int mO = inv ^ shot;
    int len = (n + 1) * (p + 1);
    int matchAt = (c + 1) * (p + 1);
    startCfg(n, c, p, ctrlWord(1, inv, shot, mM, mO));
    for (int j = 0; j < 3 * len + 2; j++) begin
      int t = j / (p + 1);
      int cv = t % (n + 1);
      int expOut = (shot != 0 && j >= len) ? 0 : (inv ^ ((cv < c) ? 1 : 0));
      int pO = (j >= len) ? 1 : 0;
      int pM = (c <= n && j >= matchAt) ? 1 : 0;
      check(int'(pwmOut), expOut, "R1 R2 R3 R4 R5 output");
      check(int'(irqOverflow), pO & (1 - mO), "R6 R7 overflow irq");
      check(int'(irqMatch), pM & (1 - mM), "R6 R7 match irq");
      @(negedge clk);
    end
    // unmasking exposes the sticky flags
    wr(3, ctrlWord(1, inv, shot, 0, 0));
    check(int'(irqOverflow), 1, "R7 unmasked overflow");
    check(int'(irqMatch), (c <= n) ? 1 : 0, "R7 unmasked match");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(pwmOut), 0, "R10 reset out");
    check(int'(irqMatch), 0, "R10 reset irqMatch");
    check(int'(irqOverflow), 0, "R10 reset irqOverflow");
    rstN = 1'b1;
    @(negedge clk);

    for (int n = 0; n <= 4; n++)
      for (int c = 0; c <= 6; c++)
        for (int p = 0; p <= 2; p++)
          for (int inv = 0; inv <= 1; inv++)
            for (int shot = 0; shot <= 1; shot++)
              sweepOne(n, c, p, inv, shot);

    // R6 write-one-to-clear: N=2 C=1 P=0; overflow ends cycles 2,5,8; match ends 1,4,7
    startCfg(2, 1, 0, ctrlWord(1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    check(int'(irqOverflow), 1, "R6 overflow set");
    wr(4, 2);
    check(int'(irqOverflow), 0, "R6 overflow cleared");
    check(int'(irqMatch), 1, "R6 match kept");
    @(negedge clk);
    @(negedge clk);
    check(int'(irqOverflow), 1, "R6 overflow reset");
    wr(4, 1);
    check(int'(irqMatch), 0, "R6 match cleared");
    check(int'(irqOverflow), 1, "R6 overflow kept");
    @(negedge clk);
    check(int'(irqMatch), 1, "R6 match reset");

    // R8 staged reload: N=3 C=1 P=0
    startCfg(3, 1, 0, ctrlWord(1, 0, 0, 0, 0));
    check(int'(pwmOut), 1, "R8 cycle0");
    @(negedge clk);
    check(int'(pwmOut), 0, "R8 cycle1");
    wr(1, 3);
    check(int'(pwmOut), 0, "R8 old compare cycle2");
    @(negedge clk);
    check(int'(pwmOut), 0, "R8 old compare cycle3");
    @(negedge clk);
    check(int'(pwmOut), 1, "R8 new compare cycle4");
    wr(0, 1);
    check(int'(pwmOut), 1, "R8 cycle5");
    wr(1, 1);
    check(int'(pwmOut), 1, "R8 old period cycle6");
    @(negedge clk);
    check(int'(pwmOut), 0, "R8 old period cycle7");
    @(negedge clk);
    check(int'(pwmOut), 1, "R8 cycle8");
    @(negedge clk);
    check(int'(pwmOut), 0, "R8 new compare cycle9");
    @(negedge clk);
    check(int'(pwmOut), 1, "R8 new period cycle10");

    // R9 disable with invert set, then fresh one-shot
    wr(3, ctrlWord(0, 1, 0, 0, 0));
    check(int'(pwmOut), 0, "R9 disabled inverted out");
    startCfg(2, 2, 1, ctrlWord(1, 1, 1, 0, 0));
    for (int j = 0; j < 9; j++) begin
      check(int'(pwmOut), (j >= 6) ? 0 : ((((j / 2) % 3) < 2) ? 0 : 1), "R5 inverted one-shot");
      @(negedge clk);
    end
    wr(3, 0);
    wr(3, ctrlWord(1, 0, 1, 0, 0));
    for (int j = 0; j < 9; j++) begin
      check(int'(pwmOut), (j >= 6) ? 0 : ((((j / 2) % 3) < 2) ? 1 : 0), "R9 fresh one-shot");
      @(negedge clk);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule